// File: doc/BRIEF.md
# PCI Slot Hotplug Event Register Block

This block sits on a simple port-I/O bus and tells an ACPI-style host that a PCI slot has been populated or emptied. A platform agent presents a hotplug event as a slot number, an insert/remove flag and a one-cycle valid strobe. The block records the event in two 32-bit slot bitmaps, one for arrivals and one for departures. It raises a general-purpose event bit in a status/enable pair and pulses the system control interrupt line. The host then reads the bitmaps and acknowledges the status bit. To request removal, it writes a one-hot slot mask to an eject port. The block decodes that mask to a slot index for the platform.

Event handling is sequenced by a small state machine with three named states:

- `EV_IDLE` accepts a strobe.
- `EV_APPLY` is the single cycle in which both bitmaps are rewritten and the event bit is set.
- `EV_SIGNAL` is the single cycle in which the interrupt is high.

The transitions are:

- **accept**: `EV_IDLE` to `EV_APPLY`, when `evt_valid` is high.
- **commit**: `EV_APPLY` to `EV_SIGNAL`, always.
- **finish**: `EV_SIGNAL` to `EV_IDLE`, always.
- **wait**: `EV_IDLE` stays in `EV_IDLE` while there is no strobe.

Top module: `hp_evt_regs`

## Requirements
- R1: After synchronous active-high reset, every register reads zero, and `sci` and `eject_valid` are low.
- R2: The arrival bitmap is at address 0xAE00 and the departure bitmap is at 0xAE04. Both take full 32-bit writes and read back what was written. `bus_rdata` follows `bus_addr` in the same cycle while `bus_rd` is high, and it is zero while `bus_rd` is low.
- R3: The clock edge after the one that samples `evt_valid` rewrites both bitmaps at once. For an insert (`evt_insert`=1), the arrival bitmap becomes 1<<slot and the departure bitmap becomes 0. For a remove, the departure bitmap becomes 1<<slot and the arrival bitmap becomes 0.
- R4: Every event, insert or remove, sets bit 1 (value 0x2) of both the event status and the event enable registers, and leaves their other bits unchanged.
- R5: `sci` is high for exactly one cycle per event. That cycle immediately follows the edge that updates the bitmaps.
- R6: A strobe sampled in `EV_APPLY` or `EV_SIGNAL` is dropped. It changes neither the bitmaps nor the interrupt.
- R7: The event registers are byte-wide on data bits 7:0. 0xAFE0 holds status bits 7:0 and 0xAFE1 holds status bits 15:8. 0xAFE2 holds enable bits 7:0 and 0xAFE3 holds enable bits 15:8. A 1 written to a status bit clears it. Enable bytes take the written value.
- R8: A write of a nonzero value to 0xAE08 raises `eject_valid` for one cycle, in the cycle after the write edge. In that cycle `eject_slot` is the position of the lowest set bit of the value. A write of zero raises nothing, and a read of 0xAE08 returns zero.
- R9: A read of any other address returns zero, and a write to any other address changes nothing (for example 0xAE02, 0xAE0C, 0xAFE4).
- R10: In the `EV_APPLY` cycle, the event update wins over a bus write to either bitmap. It also wins over a clearing write to status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| evt_valid | input | 1 | Hotplug event strobe |
| evt_slot | input | 5 | Slot number of the event |
| evt_insert | input | 1 | 1 = insertion, 0 = removal |
| sci | output | 1 | One-cycle interrupt pulse |
| eject_valid | output | 1 | Eject request strobe |
| eject_slot | output | 5 | Decoded slot index of the eject request |

## Verification
The bitmap and status update of `EV_APPLY` can fall in the same cycle as a host bus write to the same registers. The bench provokes this by driving a write of 0xFFFFFFFF to the arrival bitmap exactly in the cycle after the strobe. In a second event, it drives a clearing write of 0x02 to the status low byte in that same cycle. It judges the outcome by reading back the registers and expecting the event's values. A second collision, a new strobe arriving while the machine is in `EV_APPLY`, is judged the same way: the first event's bitmaps must stand untouched.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_APPLY  = 2'd1,
        EV_SIGNAL = 2'd2
    } ev_state_t;
endpackage

// File: rtl/hp_evt_fsm.sv
module hp_evt_fsm
    import hp_evt_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic              evt_insert,
    output logic              apply,
    output logic              sci,
    output logic [SLOT_W-1:0] cap_slot,
    output logic              cap_insert
);
    ev_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= EV_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:   if (evt_valid) state_d = EV_APPLY;
            EV_APPLY:  state_d = EV_SIGNAL;
            EV_SIGNAL: state_d = EV_IDLE;
            default:   state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        apply = 1'b0;
        sci   = 1'b0;
        unique case (state_q)
            EV_IDLE:   ;
            EV_APPLY:  apply = 1'b1;
            EV_SIGNAL: sci   = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_slot   <= '0;
            cap_insert <= 1'b0;
        end else if (state_q == EV_IDLE && evt_valid) begin
            cap_slot   <= evt_slot;
            cap_insert <= evt_insert;
        end
    end

    // R5
    sci_single_chk: assert property (@(posedge clk) disable iff (rst) sci |=> !sci);
    // R5
    apply_to_sci_chk: assert property (@(posedge clk) disable iff (rst) apply |=> sci);
    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sci |-> ($stable(cap_slot) && $stable(cap_insert)));
endmodule

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] GPE_BASE = 16'hafe0,
    parameter int              EVT_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        wbyte,
    input  logic              set_evt,
    output logic [15:0]       sts,
    output logic [15:0]       en,
    output logic [7:0]        rd_byte
);
    localparam int LANES = 2;

    logic [LANES-1:0] sts_hit, en_hit;
    logic [7:0] sts_rd [LANES];
    logic [7:0] en_rd  [LANES];

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        localparam int LO = 8 * b;
        logic [7:0] set_mask;
        assign sts_hit[b] = bus_wr && (bus_addr == GPE_BASE + ADDR_W'(b));
        assign en_hit[b]  = bus_wr && (bus_addr == GPE_BASE + ADDR_W'(LANES + b));
        assign set_mask   = set_evt ? 8'((16'(1) << EVT_BIT) >> LO) : 8'h00;

        always_ff @(posedge clk) begin
            if (rst) begin
                sts[LO +: 8] <= 8'h00;
                en[LO +: 8]  <= 8'h00;
            end else begin
                if (sts_hit[b]) sts[LO +: 8] <= (sts[LO +: 8] & ~wbyte) | set_mask;
                else            sts[LO +: 8] <= sts[LO +: 8] | set_mask;
                if (en_hit[b])  en[LO +: 8]  <= wbyte | set_mask;
                else            en[LO +: 8]  <= en[LO +: 8] | set_mask;
            end
        end

        assign sts_rd[b] = (bus_addr == GPE_BASE + ADDR_W'(b))         ? sts[LO +: 8] : 8'h00;
        assign en_rd[b]  = (bus_addr == GPE_BASE + ADDR_W'(LANES + b)) ? en[LO +: 8]  : 8'h00;
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int b = 0; b < LANES; b++) rd_byte = rd_byte | sts_rd[b] | en_rd[b];
    end

    // R4
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> (sts[EVT_BIT] && en[EVT_BIT]));
    // R7
    en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(en) |-> $past(set_evt || bus_wr));
endmodule

// File: rtl/hp_eject_dec.sv
module hp_eject_dec #(
    parameter int DATA_W = 32,
    parameter int SLOT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              eject_valid,
    output logic [SLOT_W-1:0] eject_slot
);
    logic [SLOT_W-1:0] low_idx;
    logic              any_set;

    always_comb begin
        low_idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (wdata[i]) low_idx = SLOT_W'(i);
        end
        any_set = |wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eject_valid <= 1'b0;
            eject_slot  <= '0;
        end else begin
            eject_valid <= wr_hit && any_set;
            if (wr_hit && any_set) eject_slot <= low_idx;
        end
    end

    // R8
    eject_src_chk: assert property (@(posedge clk) disable iff (rst)
        eject_valid |-> ($past(wr_hit) && ($past(wdata) != '0)));
endmodule

// File: rtl/hp_evt_regs.sv
module hp_evt_regs #(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] SLOT_BASE  = 16'hae00,
    parameter logic [ADDR_W-1:0] EJECT_ADDR = 16'hae08,
    parameter logic [ADDR_W-1:0] GPE_BASE   = 16'hafe0,
    parameter int                EVT_BIT    = 1,
    localparam int               SLOT_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_valid,
    input  logic [SLOT_W-1:0] evt_slot,
    input  logic              evt_insert,
    output logic              sci,
    output logic              eject_valid,
    output logic [SLOT_W-1:0] eject_slot
);
    localparam logic [ADDR_W-1:0] DOWN_ADDR = SLOT_BASE + ADDR_W'(4);

    logic              apply;
    logic [SLOT_W-1:0] cap_slot;
    logic              cap_insert;
    logic [DATA_W-1:0] up_q, down_q, one_hot;
    logic [15:0]       gpe_sts, gpe_en;
    logic [7:0]        gpe_byte;
    logic              up_hit, down_hit, ej_hit;

    hp_evt_fsm #(.SLOT_W(SLOT_W)) u_fsm (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_slot(evt_slot),
        .evt_insert(evt_insert), .apply(apply), .sci(sci),
        .cap_slot(cap_slot), .cap_insert(cap_insert)
    );

    hp_gpe_regs #(.ADDR_W(ADDR_W), .GPE_BASE(GPE_BASE), .EVT_BIT(EVT_BIT)) u_gpe (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .wbyte(bus_wdata[7:0]), .set_evt(apply),
        .sts(gpe_sts), .en(gpe_en), .rd_byte(gpe_byte)
    );

    assign ej_hit = bus_wr && (bus_addr == EJECT_ADDR);

    hp_eject_dec #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_ej (
        .clk(clk), .rst(rst), .wr_hit(ej_hit), .wdata(bus_wdata),
        .eject_valid(eject_valid), .eject_slot(eject_slot)
    );

    assign up_hit   = bus_wr && (bus_addr == SLOT_BASE);
    assign down_hit = bus_wr && (bus_addr == DOWN_ADDR);
    assign one_hot  = DATA_W'(1) << cap_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q   <= '0;
            down_q <= '0;
        end else if (apply) begin
            up_q   <= cap_insert ? one_hot : '0;
            down_q <= cap_insert ? '0 : one_hot;
        end else begin
            if (up_hit)   up_q   <= bus_wdata;
            if (down_hit) down_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == SLOT_BASE)      bus_rdata = up_q;
            else if (bus_addr == DOWN_ADDR) bus_rdata = down_q;
            else                            bus_rdata = DATA_W'(gpe_byte);
        end
    end

    // R3
    one_slot_chk: assert property (@(posedge clk) disable iff (rst)
        apply |=> ($countones(up_q | down_q) == 1));
    // R10
    apply_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (apply && up_hit && !cap_insert) |=> (up_q == '0));
    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/tb_hp_evt_regs.sv
module tb_hp_evt_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_slot = '0;
    logic        evt_insert = 1'b0;
    logic        sci, eject_valid;
    logic [4:0]  eject_slot;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;

    hp_evt_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
        .evt_slot(evt_slot), .evt_insert(evt_insert), .sci(sci),
        .eject_valid(eject_valid), .eject_slot(eject_slot)
    );

    task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read values as the design produces them
    always @(negedge clk) begin
        if (bus_rd && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check1(e.tag, bus_rdata, e.exp);
        end
    end

    task automatic rd_exp(logic [15:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        q.push_back('{exp: exp, tag: tag});
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic event_chk(logic [4:0] s, logic ins);
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_slot = s; evt_insert = ins;
        @(posedge clk); #1;
        evt_valid = 1'b0;
        @(posedge clk);
        @(negedge clk); check1("R5 sci high", 32'(sci), 32'd1);
        @(posedge clk);
        @(negedge clk); check1("R5 sci one cycle", 32'(sci), 32'd0);
    endtask

    task automatic eject_chk(logic [31:0] d, logic ev, logic [4:0] es);
        @(posedge clk); #1;
        bus_addr = 16'hae08; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(negedge clk);
        check1("R8 eject_valid", 32'(eject_valid), 32'(ev));
        if (ev) check1("R8 eject_slot", 32'(eject_slot), 32'(es));
        @(negedge clk);
        check1("R8 eject single", 32'(eject_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check1("R1 sci", 32'(sci), 32'd0);
        check1("R1 eject_valid", 32'(eject_valid), 32'd0);
        rd_exp(16'hae00, 32'h0, "R1 up");
        rd_exp(16'hae04, 32'h0, "R1 down");
        rd_exp(16'hafe0, 32'h0, "R1 sts");
        rd_exp(16'hafe2, 32'h0, "R1 en");

        // R2
        wr(16'hae00, 32'h1234_5678);
        wr(16'hae04, 32'h9abc_def0);
        rd_exp(16'hae00, 32'h1234_5678, "R2 up rw");
        rd_exp(16'hae04, 32'h9abc_def0, "R2 down rw");
        @(posedge clk); #1 bus_addr = 16'hae00; bus_rd = 1'b0;
        @(negedge clk); check1("R2 rdata idle", bus_rdata, 32'h0);

        // R9
        wr(16'hae02, 32'hdead_beef);
        wr(16'hae0c, 32'hdead_beef);
        wr(16'hafe4, 32'h0000_00ff);
        rd_exp(16'hae00, 32'h1234_5678, "R9 up untouched");
        rd_exp(16'hae04, 32'h9abc_def0, "R9 down untouched");
        rd_exp(16'hae0c, 32'h0, "R9 unmapped read");
        rd_exp(16'hafe4, 32'h0, "R9 beyond window");
        rd_exp(16'hae08, 32'h0, "R8 eject read zero");

        // R3 insert / R4
        event_chk(5'd7, 1'b1);
        rd_exp(16'hae00, 32'h0000_0080, "R3 insert up");
        rd_exp(16'hae04, 32'h0, "R3 insert down cleared");
        rd_exp(16'hafe0, 32'h2, "R4 sts bit");
        rd_exp(16'hafe2, 32'h2, "R4 en bit");

        // R7
        wr(16'hafe3, 32'h0000_00a5);
        rd_exp(16'hafe3, 32'ha5, "R7 en high byte");
        wr(16'hafe2, 32'h0000_0010);
        rd_exp(16'hafe2, 32'h10, "R7 en low direct");
        wr(16'hafe1, 32'h0000_00ff);
        rd_exp(16'hafe1, 32'h0, "R7 sts high w1c");
        wr(16'hafe0, 32'h0000_0002);
        rd_exp(16'hafe0, 32'h0, "R7 sts w1c");

        // R3 remove, slot 31, R4 keeps other enable bits
        event_chk(5'd31, 1'b0);
        rd_exp(16'hae04, 32'h8000_0000, "R3 remove down");
        rd_exp(16'hae00, 32'h0, "R3 remove up cleared");
        rd_exp(16'hafe2, 32'h12, "R4 en or");
        rd_exp(16'hafe3, 32'ha5, "R4 en high kept");

        // R6: second strobe during EV_APPLY is dropped
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_slot = 5'd3; evt_insert = 1'b1;
        @(posedge clk); #1;
        evt_slot = 5'd9; evt_insert = 1'b0;
        @(posedge clk); #1;
        evt_valid = 1'b0;
        @(negedge clk); check1("R6 sci once", 32'(sci), 32'd1);
        @(negedge clk); check1("R6 no second sci", 32'(sci), 32'd0);
        @(negedge clk); check1("R6 no late sci", 32'(sci), 32'd0);
        rd_exp(16'hae00, 32'h0000_0008, "R6 up first event");
        rd_exp(16'hae04, 32'h0, "R6 down untouched");

        // R10: bitmap write collides with EV_APPLY
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_slot = 5'd0; evt_insert = 1'b1;
        @(posedge clk); #1;
        evt_valid = 1'b0;
        bus_addr = 16'hae00; bus_wdata = 32'hffff_ffff; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        rd_exp(16'hae00, 32'h1, "R10 event beats up write");

        // R10: status clear collides with EV_APPLY
        wr(16'hafe0, 32'h0000_0002);
        rd_exp(16'hafe0, 32'h0, "R10 sts cleared before");
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_slot = 5'd4; evt_insert = 1'b0;
        @(posedge clk); #1;
        evt_valid = 1'b0;
        bus_addr = 16'hafe0; bus_wdata = 32'h2; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        rd_exp(16'hafe0, 32'h2, "R10 set beats w1c");
        rd_exp(16'hae04, 32'h10, "R10 down slot4");

        // R8
        eject_chk(32'h0000_0028, 1'b1, 5'd3);
        eject_chk(32'h8000_0000, 1'b1, 5'd31);
        eject_chk(32'h0000_0001, 1'b1, 5'd0);
        eject_chk(32'h0, 1'b0, 5'd0);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule